// File: doc/BRIEF.md
# Two-Class Round-Robin Bus Arbiter

This block is the central arbiter of a shared message bus. Several masters each drive a request line and a qualifier that marks the pending message as a data (frame-forwarding) transfer. The arbiter returns a one-hot grant. Data messages form the high class and command messages form the low class. A low-class request is served only when no high-class request is pending. Inside each class the masters take turns in round-robin order, and each class keeps its own pointer. The arbiter also drives a shared line that shows whether any high-class request is present.

A grant lasts one tenure. The granted master raises the shared envelope line and drops it when its message is finished. The arbiter then removes the grant and leaves the bus idle for one cycle before it arbitrates again. No new grant is issued while the envelope line is high.

A separate budget counter tracks how many data streams are active. Masters report each stream that opens or closes. An overload output is raised while that count reaches or exceeds a configurable limit.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After a synchronous reset, `gnt_o` is all zero, and `hi_any_o` and `ovld_o` are 0.
- R2: At most one bit of `gnt_o` is set in any cycle.
- R3: While idle with `env_i` low, a pending request is granted on the next clock edge. While `env_i` is high, no grant is issued.
- R4: A grant is held unchanged until `env_i` has been sampled high and then sampled low. It clears on the edge that samples `env_i` low.
- R5: A cleared grant is followed by exactly one cycle with `gnt_o` zero. A waiting request is granted on the edge after that cycle.
- R6: A request with its `hi_i` bit set (high class) always wins over any request with `hi_i` clear (low class).
- R7: High-class grants rotate round-robin, starting from the index after the last high-class winner. The first high-class winner after reset is the lowest requesting index.
- R8: Low-class grants rotate round-robin with their own pointer, which the high class does not move. The first low-class winner after reset is the lowest requesting index.
- R9: `hi_any_o` is the registered OR over all masters of `req_i & hi_i`. It follows the inputs by one edge.
- R10: The stream count is updated on each edge. `stream_add_i` alone adds one and saturates at 2^CNT_W-1. `stream_del_i` alone subtracts one and stops at 0. Both together, or neither, leave the count unchanged.
- R11: `ovld_o` is 1 exactly when the updated count is greater than or equal to `limit_i`, with both taken at the same edge. This means `ovld_o` is always 1 when the limit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_REQ | Bus request, one bit per master |
| hi_i | input | NUM_REQ | Per-master qualifier: 1 marks a data (high-class) request |
| env_i | input | 1 | Shared message envelope, high while a message is on the bus |
| stream_add_i | input | 1 | One data stream opens |
| stream_del_i | input | 1 | One data stream closes |
| limit_i | input | CNT_W | Stream budget limit |
| gnt_o | output | NUM_REQ | One-hot bus grant |
| hi_any_o | output | 1 | Some master has a high-class request pending |
| ovld_o | output | 1 | Forwarding budget fully allocated |

## Verification
The hardest case to reach from the ports is one where both class pointers have moved to different positions and the classes are then mixed. That is the only way to show that a high-class tenure leaves the low-class rotation where it stopped. The stimulus runs a full low-class rotation and then hands the bus to a high-class subset. It changes the request and qualifier inputs during the envelope of the last tenure of each phase, so the next arbitration sees the new mix at once. Other directed cases cover a count driven into its floor and its ceiling, which would wrap if it were not clamped. They also cover a request raised while a foreign envelope holds the bus.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GRANTED = 2'd1,
    ST_ACTIVE  = 2'd2
  } arb_state_t;

  localparam int CLS_HI  = 0;
  localparam int CLS_LO  = 1;
  localparam int NUM_CLS = 2;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] last_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  // Scan from the farthest offset down to the nearest one, so that the
  // nearest set bit after last_i is the one left in idx_o.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int off = N; off >= 1; off--) begin
      if (vec_i[(int'(last_i) + off) % N]) begin
        found_o = 1'b1;
        idx_o   = IW'((int'(last_i) + off) % N);
      end
    end
  end

endmodule

// File: rtl/arb_stream_budget.sv
module arb_stream_budget #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_i,
  input  logic             del_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             ovld_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    case ({add_i, del_i})
      2'b10:   cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      2'b01:   cnt_nxt = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ovld_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      ovld_o <= (cnt_nxt >= limit_i);
    end
  end

  assert_saturate_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && add_i && !del_i) |=> (cnt_q == CNT_MAX));

  assert_floor_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && del_i && !add_i) |=> (cnt_q == '0));

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import prio_arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic [NUM_REQ-1:0] hi_i,
  input  logic               env_i,
  input  logic               stream_add_i,
  input  logic               stream_del_i,
  input  logic [CNT_W-1:0]   limit_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic               hi_any_o,
  output logic               ovld_o
);

  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam logic [IW-1:0] LAST_INIT = IW'(NUM_REQ - 1);

  arb_state_t          state_q;
  logic [NUM_REQ-1:0]  hi_vec;
  logic [NUM_REQ-1:0]  lo_vec;
  logic [NUM_REQ-1:0]  cls_vec   [NUM_CLS];
  logic [IW-1:0]       cls_last  [NUM_CLS];
  logic                cls_found [NUM_CLS];
  logic [IW-1:0]       cls_idx   [NUM_CLS];

  assign hi_vec = req_i & hi_i;
  assign lo_vec = req_i & ~hi_i;
  assign cls_vec[CLS_HI] = hi_vec;
  assign cls_vec[CLS_LO] = lo_vec;

  // One round-robin picker per priority class.
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    arb_rr_pick #(.N(NUM_REQ), .IW(IW)) u_pick (
      .vec_i   (cls_vec[c]),
      .last_i  (cls_last[c]),
      .found_o (cls_found[c]),
      .idx_o   (cls_idx[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q          <= ST_IDLE;
      gnt_o            <= '0;
      hi_any_o         <= 1'b0;
      cls_last[CLS_HI] <= LAST_INIT;
      cls_last[CLS_LO] <= LAST_INIT;
    end else begin
      hi_any_o <= |hi_vec;
      case (state_q)
        ST_IDLE: begin
          if (!env_i) begin
            if (cls_found[CLS_HI]) begin
              gnt_o            <= NUM_REQ'(1) << cls_idx[CLS_HI];
              cls_last[CLS_HI] <= cls_idx[CLS_HI];
              state_q          <= ST_GRANTED;
            end else if (cls_found[CLS_LO]) begin
              gnt_o            <= NUM_REQ'(1) << cls_idx[CLS_LO];
              cls_last[CLS_LO] <= cls_idx[CLS_LO];
              state_q          <= ST_GRANTED;
            end
          end
        end
        ST_GRANTED: begin
          if (env_i) state_q <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (!env_i) begin
            gnt_o   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: begin
          gnt_o   <= '0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  arb_stream_budget #(.CNT_W(CNT_W)) u_budget (
    .clk     (clk),
    .rst     (rst),
    .add_i   (stream_add_i),
    .del_i   (stream_del_i),
    .limit_i (limit_i),
    .ovld_o  (ovld_o)
  );

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  assert_no_grant_in_env_R3: assert property (@(posedge clk) disable iff (rst)
    (env_i && gnt_o == '0) |=> (gnt_o == '0));

  assert_grant_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt_o != '0) |=> (gnt_o == $past(gnt_o) || gnt_o == '0));

  assert_release_after_env_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(|gnt_o) |-> (!$past(env_i) && $past(env_i, 2)));

  assert_high_first_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(|gnt_o) |-> ($past(hi_vec) == '0 || (gnt_o & $past(hi_vec)) != '0));

endmodule

// File: tb/sim_prio_bus_arbiter.sv
module sim_prio_bus_arbiter;

  localparam int N  = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  req;
  logic [N-1:0]  hi;
  logic          env;
  logic          sadd;
  logic          sdel;
  logic [CW-1:0] limit;
  logic [N-1:0]  gnt;
  logic          hi_any;
  logic          ovld;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_bus_arbiter #(.NUM_REQ(N), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .hi_i(hi), .env_i(env),
    .stream_add_i(sadd), .stream_del_i(sdel), .limit_i(limit),
    .gnt_o(gnt), .hi_any_o(hi_any), .ovld_o(ovld)
  );

  // Packing: {unused, add, del, limit[3:0], expected ovld}
  localparam logic [7:0] OV_TAB [13] = '{
    8'b0_1_0_0010_0, 8'b0_1_0_0010_1, 8'b0_1_1_0010_1, 8'b0_0_0_0010_1,
    8'b0_0_1_0010_0, 8'b0_1_0_0001_1, 8'b0_0_1_0001_1, 8'b0_0_1_0001_0,
    8'b0_0_1_0001_0, 8'b0_1_0_0001_1, 8'b0_0_0_0000_1, 8'b0_0_1_0000_1,
    8'b0_0_0_0011_0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // One full tenure: grant on the next edge, envelope for two cycles, release.
  task automatic tenure(input int idx, input logic [N-1:0] nreq,
                        input logic [N-1:0] nhi, input string tag);
    tick();
    chk(tag, 32'(gnt), 32'(1) << idx);
    @(negedge clk) env = 1'b1;
    for (int k = 0; k < 2; k++) begin
      tick();
      chk("R4 grant held in envelope", 32'(gnt), 32'(1) << idx);
    end
    @(negedge clk) begin
      req = nreq;
      hi  = nhi;
      env = 1'b0;
    end
    tick();
    chk("R4/R5 grant cleared after envelope", 32'(gnt), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req = '0; hi = '0; env = 1'b0;
    sadd = 1'b0; sdel = 1'b0; limit = 4'd3;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset grant", 32'(gnt), 32'd0);
    chk("R1 reset hi_any", 32'(hi_any), 32'd0);
    chk("R1 reset ovld", 32'(ovld), 32'd0);
    @(negedge clk) rst = 1'b0;

    // Table walk for the stream budget (R10, R11)
    foreach (OV_TAB[i]) begin
      @(negedge clk) begin
        sadd  = OV_TAB[i][6];
        sdel  = OV_TAB[i][5];
        limit = OV_TAB[i][4:1];
      end
      tick();
      chk($sformatf("R10/R11 budget row %0d", i), 32'(ovld), 32'(OV_TAB[i][0]));
    end
    @(negedge clk) begin sadd = 1'b0; sdel = 1'b0; limit = 4'd15; end

    // Saturation at the top of the count (R10)
    for (int k = 0; k < 16; k++) begin
      @(negedge clk) sadd = 1'b1;
      tick();
    end
    chk("R10 count reaches max", 32'(ovld), 32'd1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk) sadd = 1'b1;
      tick();
    end
    chk("R10 count saturates", 32'(ovld), 32'd1);
    @(negedge clk) begin sadd = 1'b0; sdel = 1'b1; end
    tick();
    chk("R11 below limit after one close", 32'(ovld), 32'd0);
    @(negedge clk) sdel = 1'b0;

    // Low-class rotation (R3, R8)
    @(negedge clk) begin req = 4'b1111; hi = 4'b0000; end
    tenure(0, 4'b1111, 4'b0000, "R8 low first after reset");
    tenure(1, 4'b1111, 4'b0000, "R5/R8 low rotate 1");
    tenure(2, 4'b1111, 4'b0000, "R8 low rotate 2");
    tenure(3, 4'b1111, 4'b0000, "R8 low rotate 3");
    tenure(0, 4'b1111, 4'b1010, "R8 low wrap");
    chk("R9 hi_any raised", 32'(hi_any), 32'd1);

    // High class preempts low and rotates on its own (R6, R7)
    tenure(1, 4'b1111, 4'b1010, "R6/R7 high first");
    tenure(3, 4'b1111, 4'b1010, "R7 high rotate");
    tenure(1, 4'b1111, 4'b0000, "R7 high wrap");
    chk("R9 hi_any cleared", 32'(hi_any), 32'd0);

    // Low pointer resumes where it stopped (R8)
    tenure(1, 4'b0000, 4'b0000, "R8 low pointer kept");
    for (int k = 0; k < 2; k++) begin
      tick();
      chk("R3 no request no grant", 32'(gnt), 32'd0);
    end

    // Foreign envelope blocks grants (R3)
    @(negedge clk) begin env = 1'b1; req = 4'b0100; hi = 4'b0100; end
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3 no grant while envelope high", 32'(gnt), 32'd0);
    end
    chk("R9 hi_any during envelope", 32'(hi_any), 32'd1);
    @(negedge clk) env = 1'b0;
    tenure(2, 4'b1001, 4'b0001, "R3/R7 grant after envelope");

    // Mixed single high vs low (R6)
    tenure(0, 4'b0000, 4'b0000, "R6 high beats low");
    tick();
    chk("R2 idle grant zero", 32'(gnt), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule